// File: doc/BRIEF.md
# Twin-Channel Phase Detector Control Core

This block is the digital control heart of a two-channel frequency synthesizer. Each channel has a reset-based phase-frequency detector. It compares a reference-divider strobe against a feedback-divider strobe. The result drives a pair of charge-pump enables (source and sink). Those enables can be inverted by a polarity bit, or silenced by a tristate bit or by power-down. Each channel can be powered either from its software bit alone, or from the software bit combined with an external power-down pin. Each channel also has a lock detector. It asserts lock once the detector's correction pulses have stayed short for a configurable run of reference cycles.

Several pins are shared, so the block decides what each one does. A pin that is not used as a power-down or current-switch input becomes an open-collector port. One output pin can show a port level, either lock, or the OR of both locks. In test mode the same pin shows one of the four divider strobes. Channel 1 also has a high-current request. It comes from a control bit and can optionally be qualified by an external pin. All strobes and pins are assumed synchronous to `clk`.

Top module: `pdc_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after it, all detector flags and lock counters are clear. So `cp_src`, `cp_snk` and `lock` are all 0.
- R2: Each channel has two flags: a reference-leads flag and a feedback-leads flag. A reference strobe sets the reference-leads flag and a feedback strobe sets the feedback-leads flag, from the next cycle on. When both flags would be set, both clear instead. Strobes that arrive in the same cycle with both flags clear cause no action.
- R3: With polarity 1, the reference-leads flag enables sink and the feedback-leads flag enables source. With polarity 0 the two are swapped. Source and sink are both 0 when no flag is set.
- R4: `cp_hiz[c]` is 1 when the channel's tristate bit is 1 or the channel is off. While it is 1, `cp_src[c]` and `cp_snk[c]` are 0.
- R5: A channel is on (`ch_on[c]`) when its hardware-select bit is 0 and its software bit is 1. It is also on when both of those bits are 1 and `pin_hpd[c]` is high. While a channel is off, its flags and its lock counter are held clear.
- R6: `port_low[i]` is 1 (the output pulls low) exactly when that pin acts as a port and `cfg_port[i]` is 0. Bit 0 acts as a port when `cfg_cur_pin_en`=0. Bit 1 acts as a port when `cfg_hw_sel[0]`=0. Bit 4 acts as a port when `cfg_hw_sel[1]`=0. Bit 3 is always a port. Bit 2 always follows the shared pin: `port_low[2]` = NOT `lock_pin`.
- R7: `cp_hicur` = `cfg_hicur` AND (NOT `cfg_cur_pin_en` OR `pin_cur`).
- R8: Each channel keeps a count of reference strobes. A strobe adds one to the count, saturating at LOCK_REFS. The count resets to 0 if, at any time since the previous strobe (that strobe's cycle included), a flag stayed set for more than WIN_CYC cycles. `lock[c]` is 1 when the count equals LOCK_REFS.
- R9: With `cfg_test`=0, `cfg_lsel` selects what `lock_pin` shows. 00 gives `cfg_port[2]`. 01 gives `lock[1]`. 10 gives `lock[0]`. 11 gives `lock[0]` OR `lock[1]`.
- R10: With `cfg_test`=1, `cfg_lsel`=10 shows `ref_pls[0]` when `cfg_pol[0]`=1 and `fb_pls[0]` when it is 0. `cfg_lsel`=01 shows `ref_pls[1]` or `fb_pls[1]` under the same rule with `cfg_pol[1]`. The other two codes leave `lock_pin` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pls | input | 2 | Reference-divider strobes, one per channel |
| fb_pls | input | 2 | Feedback-divider strobes, one per channel |
| cfg_pol | input | 2 | Pump polarity per channel (1 = normal) |
| cfg_tri | input | 2 | Pump tristate per channel |
| cfg_sw_on | input | 2 | Software power bit per channel (1 = on) |
| cfg_hw_sel | input | 2 | Use the power-down pin per channel |
| pin_hpd | input | 2 | Power-down pin levels (high = on) |
| cfg_port | input | 5 | Port register bits (1 = released) |
| cfg_lsel | input | 2 | Shared-pin selection code |
| cfg_test | input | 1 | Counter test mode on the shared pin |
| cfg_hicur | input | 1 | Channel 1 high-current request |
| cfg_cur_pin_en | input | 1 | Qualify high current with `pin_cur` |
| pin_cur | input | 1 | Current-switch pin level |
| cp_src | output | 2 | Source enable per channel |
| cp_snk | output | 2 | Sink enable per channel |
| cp_hiz | output | 2 | Pump high-impedance per channel |
| ch_on | output | 2 | Channel powered |
| lock | output | 2 | Lock indication per channel |
| lock_pin | output | 1 | Shared lock/port/test pin level |
| port_low | output | 5 | Open-collector pull-low per port |
| cp_hicur | output | 1 | Channel 1 high-current enable |

## Verification
Two things can land in the same clock edge: a flag being set or cleared in a detector, and a lock-counter decision for that channel. One case is a reference strobe that arrives while an over-long correction pulse is being judged. The other is a power-down that arrives as the lock count saturates. The bench provokes these with fixed phase offsets that sit exactly at the window and one cycle past it, and then with long stretches of random strobes, power pins and configuration changes. A behavioural model of the counters and flags predicts every output, and the prediction is compared against the outputs on each cycle.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [1:0] {
    LSEL_PORT = 2'b00,
    LSEL_LK2  = 2'b01,
    LSEL_LK1  = 2'b10,
    LSEL_OR   = 2'b11
  } lsel_e;

  // channel power from software bit, select bit and pin level
  function automatic logic chan_power(logic hw_sel, logic sw_on, logic hpd);
    return sw_on & (~hw_sel | hpd);
  endfunction

  // {source, sink} from lead flags and polarity
  function automatic logic [1:0] pump_dir(logic ref_lead, logic fb_lead, logic pol);
    return pol ? {fb_lead, ref_lead} : {ref_lead, fb_lead};
  endfunction

  function automatic logic hi_current(logic en, logic pin_en, logic pin);
    return en & (~pin_en | pin);
  endfunction

  // shared pin level, normal and test selection
  function automatic logic shared_pin(lsel_e sel, logic test, logic p2,
                                      logic [1:0] lk, logic [1:0] pol,
                                      logic [1:0] rp, logic [1:0] fp);
    logic v;
    if (!test) begin
      case (sel)
        LSEL_PORT: v = p2;
        LSEL_LK2:  v = lk[1];
        LSEL_LK1:  v = lk[0];
        default:   v = lk[0] | lk[1];
      endcase
    end else begin
      case (sel)
        LSEL_LK1: v = pol[0] ? rp[0] : fp[0];
        LSEL_LK2: v = pol[1] ? rp[1] : fp[1];
        default:  v = 1'b1;
      endcase
    end
    return v;
  endfunction

endpackage

// File: rtl/pdc_pfd.sv
module pdc_pfd
  import pdc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic ref_pls,
  input  logic fb_pls,
  input  logic pol,
  input  logic tri_en,
  output logic ref_lead,
  output logic fb_lead,
  output logic src,
  output logic snk,
  output logic hiz
);
  logic nxt_ref, nxt_fb, both_hit;
  logic [1:0] dir;

  always_comb begin
    nxt_ref  = ref_lead | ref_pls;
    nxt_fb   = fb_lead | fb_pls;
    both_hit = nxt_ref & nxt_fb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !on || both_hit) begin
      ref_lead <= 1'b0;
      fb_lead  <= 1'b0;
    end else begin
      ref_lead <= nxt_ref;
      fb_lead  <= nxt_fb;
    end
  end

  always_comb begin
    dir = pump_dir(ref_lead, fb_lead, pol);
    hiz = tri_en | ~on;
    src = dir[1] & ~hiz;
    snk = dir[0] & ~hiz;
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(ref_lead && fb_lead)); // R2
  AST_BOTH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (ref_lead && fb_pls) |=> (!ref_lead && !fb_lead)); // R2

endmodule

// File: rtl/pdc_lock_det.sv
module pdc_lock_det #(
  parameter int WIN_CYC   = 2,
  parameter int LOCK_REFS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic on,
  input  logic ref_pls,
  input  logic active,
  output logic locked
);
  localparam int WW = $clog2(WIN_CYC + 1) + 1;
  localparam int CW = $clog2(LOCK_REFS + 1) + 1;
  localparam logic [WW-1:0] W_MAX = WW'(WIN_CYC);
  localparam logic [CW-1:0] C_MAX = CW'(LOCK_REFS);

  logic [WW-1:0] wcnt;
  logic [CW-1:0] rcnt;
  logic          bad_seen;
  logic          too_long;
  logic          fail_now;

  always_comb begin
    too_long = active && (wcnt == W_MAX);
    fail_now = too_long | bad_seen;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !on) begin
      wcnt     <= '0;
      rcnt     <= '0;
      bad_seen <= 1'b0;
    end else begin
      if (!active)           wcnt <= '0;
      else if (wcnt != W_MAX) wcnt <= wcnt + 1'b1;
      if (ref_pls) begin
        bad_seen <= 1'b0;
        if (fail_now)          rcnt <= '0;
        else if (rcnt != C_MAX) rcnt <= rcnt + 1'b1;
      end else begin
        bad_seen <= fail_now;
      end
    end
  end

  assign locked = (rcnt == C_MAX);

  AST_OFF_NO_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
    !on |=> !locked); // R5
  AST_LOCK_ON_REF: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(ref_pls)); // R8

endmodule

// File: rtl/pdc_pin_mux.sv
module pdc_pin_mux
  import pdc_pkg::*;
(
  input  logic [1:0] lsel,
  input  logic       test,
  input  logic [1:0] pol,
  input  logic [1:0] ref_pls,
  input  logic [1:0] fb_pls,
  input  logic [1:0] lock,
  input  logic [4:0] port_cfg,
  input  logic [1:0] hw_sel,
  input  logic       cur_pin_en,
  output logic       lock_pin,
  output logic [4:0] port_low
);
  logic [4:0] is_port;

  always_comb begin
    lock_pin = shared_pin(lsel_e'(lsel), test, port_cfg[2], lock, pol, ref_pls, fb_pls);
    is_port  = {~hw_sel[1], 1'b1, 1'b0, ~hw_sel[0], ~cur_pin_en};
    port_low = is_port & ~port_cfg;
    port_low[2] = ~lock_pin;
  end

endmodule

// File: rtl/pdc_core.sv
module pdc_core
  import pdc_pkg::*;
#(
  parameter int WIN_CYC   = 2,
  parameter int LOCK_REFS = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ref_pls,
  input  logic [1:0] fb_pls,
  input  logic [1:0] cfg_pol,
  input  logic [1:0] cfg_tri,
  input  logic [1:0] cfg_sw_on,
  input  logic [1:0] cfg_hw_sel,
  input  logic [1:0] pin_hpd,
  input  logic [4:0] cfg_port,
  input  logic [1:0] cfg_lsel,
  input  logic       cfg_test,
  input  logic       cfg_hicur,
  input  logic       cfg_cur_pin_en,
  input  logic       pin_cur,
  output logic [1:0] cp_src,
  output logic [1:0] cp_snk,
  output logic [1:0] cp_hiz,
  output logic [1:0] ch_on,
  output logic [1:0] lock,
  output logic       lock_pin,
  output logic [4:0] port_low,
  output logic       cp_hicur
);
  localparam int NCH = 2;

  logic [NCH-1:0] ref_lead, fb_lead;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ch_on[c] = chan_power(cfg_hw_sel[c], cfg_sw_on[c], pin_hpd[c]);

    pdc_pfd u_pfd (
      .clk      (clk),
      .rst_n    (rst_n),
      .on       (ch_on[c]),
      .ref_pls  (ref_pls[c]),
      .fb_pls   (fb_pls[c]),
      .pol      (cfg_pol[c]),
      .tri_en   (cfg_tri[c]),
      .ref_lead (ref_lead[c]),
      .fb_lead  (fb_lead[c]),
      .src      (cp_src[c]),
      .snk      (cp_snk[c]),
      .hiz      (cp_hiz[c])
    );

    pdc_lock_det #(.WIN_CYC(WIN_CYC), .LOCK_REFS(LOCK_REFS)) u_lock (
      .clk     (clk),
      .rst_n   (rst_n),
      .on      (ch_on[c]),
      .ref_pls (ref_pls[c]),
      .active  (ref_lead[c] | fb_lead[c]),
      .locked  (lock[c])
    );

    AST_HIZ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      cp_hiz[c] |-> (!cp_src[c] && !cp_snk[c])); // R4
  end

  pdc_pin_mux u_mux (
    .lsel       (cfg_lsel),
    .test       (cfg_test),
    .pol        (cfg_pol),
    .ref_pls    (ref_pls),
    .fb_pls     (fb_pls),
    .lock       (lock),
    .port_cfg   (cfg_port),
    .hw_sel     (cfg_hw_sel),
    .cur_pin_en (cfg_cur_pin_en),
    .lock_pin   (lock_pin),
    .port_low   (port_low)
  );

  assign cp_hicur = hi_current(cfg_hicur, cfg_cur_pin_en, pin_cur);

endmodule

// File: tb/pdc_core_tb_top.sv
module pdc_core_tb_top;
  localparam int WIN  = 2;
  localparam int LREF = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n;
  logic [1:0] ref_pls, fb_pls, cfg_pol, cfg_tri, cfg_sw_on, cfg_hw_sel, pin_hpd, cfg_lsel;
  logic [4:0] cfg_port;
  logic cfg_test, cfg_hicur, cfg_cur_pin_en, pin_cur;
  logic [1:0] cp_src, cp_snk, cp_hiz, ch_on, lock;
  logic lock_pin, cp_hicur;
  logic [4:0] port_low;

  pdc_core #(.WIN_CYC(WIN), .LOCK_REFS(LREF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ref_pls(ref_pls), .fb_pls(fb_pls),
    .cfg_pol(cfg_pol), .cfg_tri(cfg_tri), .cfg_sw_on(cfg_sw_on),
    .cfg_hw_sel(cfg_hw_sel), .pin_hpd(pin_hpd), .cfg_port(cfg_port),
    .cfg_lsel(cfg_lsel), .cfg_test(cfg_test), .cfg_hicur(cfg_hicur),
    .cfg_cur_pin_en(cfg_cur_pin_en), .pin_cur(pin_cur),
    .cp_src(cp_src), .cp_snk(cp_snk), .cp_hiz(cp_hiz), .ch_on(ch_on),
    .lock(lock), .lock_pin(lock_pin), .port_low(port_low), .cp_hicur(cp_hicur)
  );

  int checks = 0, fails = 0;
  bit done = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural model ----------------
  int m_rl[2], m_fl[2], m_w[2], m_bs[2], m_cnt[2];

  function automatic bit m_on(int c);
    return cfg_sw_on[c] && (!cfg_hw_sel[c] || pin_hpd[c]);
  endfunction

  always @(posedge clk) begin
    for (int c = 0; c < 2; c++) begin
      if (!rst_n) begin
        m_rl[c] = 0; m_fl[c] = 0; m_w[c] = 0; m_bs[c] = 0; m_cnt[c] = 0;
      end else if (!m_on(c)) begin
        m_rl[c] = 0; m_fl[c] = 0; m_w[c] = 0; m_bs[c] = 0; m_cnt[c] = 0;
      end else begin
        bit act, bad, nu, nd;
        act = (m_rl[c] != 0) || (m_fl[c] != 0);
        bad = act && (m_w[c] >= WIN);
        if (ref_pls[c]) begin
          if (bad || m_bs[c] != 0) m_cnt[c] = 0;
          else if (m_cnt[c] < LREF) m_cnt[c]++;
          m_bs[c] = 0;
        end else if (bad) m_bs[c] = 1;
        m_w[c] = act ? ((m_w[c] < WIN) ? m_w[c] + 1 : WIN) : 0;
        nu = (m_rl[c] != 0) || ref_pls[c];
        nd = (m_fl[c] != 0) || fb_pls[c];
        if (nu && nd) begin m_rl[c] = 0; m_fl[c] = 0; end
        else begin m_rl[c] = nu; m_fl[c] = nd; end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      int e_src, e_snk, e_hiz, e_on, e_lk, e_pin, e_pl, e_hc;
      e_src = 0; e_snk = 0; e_hiz = 0; e_on = 0; e_lk = 0;
      for (int c = 0; c < 2; c++) begin
        bit on, hz, s, k;
        on = m_on(c);
        hz = cfg_tri[c] || !on;
        s = cfg_pol[c] ? (m_fl[c] != 0) : (m_rl[c] != 0);
        k = cfg_pol[c] ? (m_rl[c] != 0) : (m_fl[c] != 0);
        e_src |= int'(s && !hz) << c;
        e_snk |= int'(k && !hz) << c;
        e_hiz |= int'(hz) << c;
        e_on  |= int'(on) << c;
        e_lk  |= int'(m_cnt[c] == LREF) << c;
      end
      if (!cfg_test) begin
        case (cfg_lsel)
          2'b00: e_pin = cfg_port[2];
          2'b01: e_pin = (e_lk >> 1) & 1;
          2'b10: e_pin = e_lk & 1;
          default: e_pin = (e_lk != 0) ? 1 : 0;
        endcase
      end else begin
        case (cfg_lsel)
          2'b10: e_pin = cfg_pol[0] ? ref_pls[0] : fb_pls[0];
          2'b01: e_pin = cfg_pol[1] ? ref_pls[1] : fb_pls[1];
          default: e_pin = 1;
        endcase
      end
      e_pl = 0;
      if (!cfg_cur_pin_en && !cfg_port[0]) e_pl |= 1;
      if (!cfg_hw_sel[0] && !cfg_port[1]) e_pl |= 2;
      if (e_pin == 0) e_pl |= 4;
      if (!cfg_port[3]) e_pl |= 8;
      if (!cfg_hw_sel[1] && !cfg_port[4]) e_pl |= 16;
      e_hc = (cfg_hicur && (!cfg_cur_pin_en || pin_cur)) ? 1 : 0;
      chk("R2 R3", "cp_src", cp_src, e_src);
      chk("R2 R3", "cp_snk", cp_snk, e_snk);
      chk("R4", "cp_hiz", cp_hiz, e_hiz);
      chk("R5", "ch_on", ch_on, e_on);
      chk("R8", "lock", lock, e_lk);
      chk(cfg_test ? "R10" : "R9", "lock_pin", lock_pin, e_pin);
      chk("R6", "port_low", port_low, e_pl);
      chk("R7", "cp_hicur", cp_hicur, e_hc);
    end
  end

  // ---------------- stimulus generator ----------------
  int per[2] = '{8, 8};
  int off[2] = '{1, 7};
  bit rnd = 0;
  int ph = 0;

  always @(posedge clk) begin
    #1;
    ph++;
    for (int c = 0; c < 2; c++) begin
      if (rnd) begin
        ref_pls[c] = ($urandom % 5) == 0;
        fb_pls[c]  = ($urandom % 5) == 0;
      end else begin
        ref_pls[c] = (ph % per[c]) == 0;
        fb_pls[c]  = (ph % per[c]) == (off[c] % per[c]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  initial begin
    rst_n = 0;
    ref_pls = 0; fb_pls = 0;
    cfg_pol = 2'b11; cfg_tri = 0; cfg_sw_on = 2'b11; cfg_hw_sel = 0; pin_hpd = 2'b11;
    cfg_port = 5'b10101; cfg_lsel = 2'b00; cfg_test = 0; cfg_hicur = 0;
    cfg_cur_pin_en = 0; pin_cur = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "lock in reset", lock, 0);
    chk("R1", "cp_src in reset", cp_src, 0);
    chk("R1", "cp_snk in reset", cp_snk, 0);
    @(posedge clk); #2;
    rst_n = 1;
    @(negedge clk);
    chk("R1", "lock after reset", lock, 0);
    chk("R1", "cp_src|cp_snk after reset", cp_src | cp_snk, 0);
    // R8: small phase error on both channels acquires lock
    cyc(80);
    chk("R8", "lock after clean run", lock, 3);
    cfg_lsel = 2'b11; cyc(4);
    // R8: error of one cycle past the window drops lock on channel 0
    off[0] = WIN + 1; cyc(40);
    chk("R8", "ch0 unlocked on long pulse", lock & 1, 0);
    // exactly at window keeps counting
    off[0] = WIN; cyc(60);
    chk("R8", "ch0 locks at window edge", lock & 1, 1);
    // R2: coincident strobes give no action
    off[0] = 0; off[1] = 0; cyc(40);
    // R3: inverted polarity
    cfg_pol = 2'b00; off[0] = 2; off[1] = 6; cyc(40);
    cfg_pol = 2'b01; cyc(24);
    // R4: tristate
    cfg_tri = 2'b01; cyc(20); cfg_tri = 2'b10; cyc(20); cfg_tri = 0;
    // R5: hardware power-down pin
    cfg_hw_sel = 2'b11;
    for (int i = 0; i < 8; i++) begin pin_hpd = 2'(i); cyc(13); end
    pin_hpd = 2'b11; cfg_sw_on = 2'b01; cyc(20);
    cfg_hw_sel = 2'b00; cfg_sw_on = 2'b10; cyc(20);
    cfg_sw_on = 2'b11; cyc(50);
    // R9 R10: every selection in both modes, R6 R7 ports and current
    for (int t = 0; t < 2; t++)
      for (int s = 0; s < 4; s++)
        for (int p = 0; p < 4; p++) begin
          cfg_test = t[0]; cfg_lsel = 2'(s); cfg_pol = 2'(p);
          cfg_port = 5'(s * 7 + p * 3 + t);
          cfg_hicur = p[0]; cfg_cur_pin_en = p[1]; pin_cur = s[0];
          cfg_hw_sel = 2'(s + t);
          cyc(17);
        end
    cfg_test = 0; cfg_hw_sel = 0;
    // random mix
    rnd = 1;
    for (int k = 0; k < 300; k++) begin
      cfg_pol = 2'($urandom); cfg_tri = ($urandom % 4 == 0) ? 2'($urandom) : 2'b00;
      cfg_sw_on = ($urandom % 3 == 0) ? 2'($urandom) : 2'b11;
      cfg_hw_sel = 2'($urandom); pin_hpd = 2'($urandom | $urandom);
      cfg_port = 5'($urandom); cfg_lsel = 2'($urandom); cfg_test = ($urandom % 3) == 0;
      cfg_hicur = 1'($urandom); cfg_cur_pin_en = 1'($urandom); pin_cur = 1'($urandom);
      cyc(11);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    done = 1;
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule